// File: doc/BRIEF.md
# Global control register file

A bank of 32-bit system control and status words sitting on an APB-style peripheral bus inside a 4 KiB address window. Software reads and writes whole aligned words; the word index is the byte offset divided by four. Each word obeys its own access rule. Some words are read-only. Some are cleared bit by bit when software writes ones to them. Some collect ones that can never be cleared again. The rest are ordinary storage.

On reset every word loads a fixed constant, except three that take their reset value from the system. The strap word and the module-disable word copy 32-bit input pins. The memory configuration word combines a base constant with a field derived from a 3-bit memory-size code. Two status words can also have bits raised by hardware strobes. Every access completes in a single cycle. An illegal access reports a bus error and leaves the storage untouched.

Top module: `gcr_regfile`

## Requirements
- R1: Every aligned offset from 0x000 to 0x144 holds a 32-bit word. The word index is offset/4. Offsets with no special rule below, including unnamed ones, read back exactly what was last written.
- R2: After reset the fixed words hold: 0x000=0x04A92750, 0x014=0x0000FFFF, 0x038=0x00000003, 0x03C=0x0000035E, 0x050=0x0000004E, 0x060=0x00080000 (bit 19 only), 0x06C=0x80000000, 0x078=0x000000C0, 0x098=0x5A00F3CF, 0x13C=0x00000008, and 0x140 and 0x144 both 0x034730E4. Every other word not named in R6 or R7 is zero.
- R3: Words 0x000, 0x004 and 0x040 are read-only. A write to them completes without error and leaves their value unchanged.
- R4: Words 0x06C and 0x0D4 are write-one-to-clear: the new value is old AND NOT write data.
- R5: Words 0x070 and 0x07C are write-one-to-set: the new value is old OR write data, so a set bit never returns to zero.
- R6: During reset, word 0x004 loads `strap_in` and word 0x07C loads `modoff_in`.
- R7: During reset, word 0x09C loads 0x00001002 OR (effective size code shifted left by 8). The size code 0 to 4 stands for log2(size/128 MiB).
- R8: `config_error` is high exactly while `memsize_code` exceeds 4. In that case the effective code used by R7 is 0.
- R9: An access with paddr[1:0] not zero, any access above offset 0x144, or a write whose pstrb is not 4'b1111 asserts `pslverr` in its access cycle. It reads as zero and changes no word. `pready` is always high.
- R10: A high bit of `hw_set_rst` sets the same bit of word 0x06C, and a high bit of `hw_set_aux` sets the same bit of word 0x0D4. When the strobe and a clearing write hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads all reset values |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Write byte strobes; must be all ones on writes |
| prdata | output | 32 | Read data, zero on error or when idle |
| pready | output | 1 | Always high: one-cycle completion |
| pslverr | output | 1 | Error response for illegal accesses |
| strap_in | input | 32 | Reset value of the strap word |
| modoff_in | input | 32 | Reset value of the module-disable word |
| memsize_code | input | 3 | Memory size code, legal 0 to 4 |
| hw_set_rst | input | 32 | Hardware set strobes for word 0x06C |
| hw_set_aux | input | 32 | Hardware set strobes for word 0x0D4 |
| config_error | output | 1 | Size code out of range |

## Verification
The bench builds the block with its default parameters: a 12-bit address, last word at 0x144, and a 3-bit size code capped at 4. With these values the whole map can be swept, including the first offset past the end (0x148) and the window top. The code input can reach the legal maximum 4 and every illegal value from 5 to 7. Resets are repeated with different strap, module-disable and size inputs so that each pin-loaded word is seen with more than one value. A write to word 0x06C is issued together with a strobe on the same bits to exercise set-over-clear priority.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

   typedef enum logic [1:0] {
      POL_RW  = 2'd0,
      POL_RO  = 2'd1,
      POL_W1C = 2'd2,
      POL_W1S = 2'd3
   } gcr_pol_e;

   // Word indices whose behaviour is special (byte offset / 4)
   localparam int IDX_PRODID  = 0;   // 0x000
   localparam int IDX_STRAP   = 1;   // 0x004
   localparam int IDX_INTSTAT = 16;  // 0x040
   localparam int IDX_RSTSTAT = 27;  // 0x06C
   localparam int IDX_LOCK    = 28;  // 0x070
   localparam int IDX_MODOFF  = 31;  // 0x07C
   localparam int IDX_MEMCFG  = 39;  // 0x09C
   localparam int IDX_CPSTAT  = 53;  // 0x0D4
   localparam int IDX_HIGHEST = 81;  // 0x144, highest index the map relies on

   function automatic gcr_pol_e pol_of(int idx);
      case (idx)
         IDX_PRODID, IDX_STRAP, IDX_INTSTAT: return POL_RO;
         IDX_RSTSTAT, IDX_CPSTAT:            return POL_W1C;
         IDX_LOCK, IDX_MODOFF:               return POL_W1S;
         default:                            return POL_RW;
      endcase
   endfunction

   function automatic logic [31:0] fixed_rst(int idx);
      case (idx)
         IDX_PRODID:  return 32'h04A9_2750;
         5:           return 32'h0000_FFFF;
         14:          return 32'h0000_0003;
         15:          return 32'h0000_035E;
         20:          return 32'h0000_004E;
         24:          return 32'h0008_0000;
         IDX_RSTSTAT: return 32'h8000_0000;
         30:          return 32'h0000_00C0;
         38:          return 32'h5A00_F3CF;
         79:          return 32'h0000_0008;
         80, 81:      return 32'h0347_30E4;
         default:     return 32'h0000_0000;
      endcase
   endfunction

endpackage

// File: rtl/gcr_access_decode.sv
module gcr_access_decode #(
   parameter int ADDR_W   = 12,
   parameter int STRB_W   = 4,
   parameter int LAST_OFS = 'h144,
   parameter int WIDX     = 7
) (
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [STRB_W-1:0] pstrb,
   output logic              err,
   output logic              wr_ok,
   output logic              rd_ok,
   output logic [WIDX-1:0]   ridx
);

   logic acc;
   logic misaligned;
   logic beyond;
   logic part_write;

   assign acc        = psel & penable;
   assign misaligned = |paddr[1:0];
   assign beyond     = paddr > ADDR_W'(LAST_OFS);
   assign part_write = pwrite & (pstrb != {STRB_W{1'b1}});

   assign err   = acc & (misaligned | beyond | part_write);
   assign wr_ok = acc &  pwrite & ~err;
   assign rd_ok = acc & ~pwrite & ~err;
   assign ridx  = paddr[WIDX+1:2];

endmodule

// File: rtl/gcr_size_code.sv
module gcr_size_code #(
   parameter int          CODE_W    = 3,
   parameter int          CODE_MAX  = 4,
   parameter int          DATA_W    = 32,
   parameter int          FIELD_LSB = 8,
   parameter logic [31:0] BASE      = 32'h0000_1002
) (
   input  logic [CODE_W-1:0] code,
   output logic              cfg_err,
   output logic [DATA_W-1:0] memcfg_rst
);

   logic [CODE_W-1:0] eff;

   assign cfg_err    = code > CODE_W'(CODE_MAX);
   assign eff        = cfg_err ? '0 : code;
   assign memcfg_rst = DATA_W'(BASE) | (DATA_W'(eff) << FIELD_LSB);

endmodule

// File: rtl/gcr_word.sv
module gcr_word #(
   parameter int               DATA_W = 32,
   parameter gcr_pkg::gcr_pol_e POL   = gcr_pkg::POL_RW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] rst_val,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] hw_set,
   output logic [DATA_W-1:0] q
);

   logic [DATA_W-1:0] nxt;

   generate
      case (POL)
         gcr_pkg::POL_RO: begin : g_ro
            logic unused_ro;
            assign unused_ro = ^{wr, wdata, hw_set};
            assign nxt = q;
         end
         gcr_pkg::POL_W1C: begin : g_w1c
            // strobe applied after the clear: set wins
            assign nxt = (wr ? (q & ~wdata) : q) | hw_set;
         end
         gcr_pkg::POL_W1S: begin : g_w1s
            logic unused_w1s;
            assign unused_w1s = ^hw_set;
            assign nxt = wr ? (q | wdata) : q;
         end
         default: begin : g_rw
            logic unused_rw;
            assign unused_rw = ^hw_set;
            assign nxt = wr ? wdata : q;
         end
      endcase
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= rst_val;
      else        q <= nxt;
   end

endmodule

// File: rtl/gcr_regfile.sv
module gcr_regfile #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 12,
   parameter int LAST_OFS = 'h144,
   parameter int CODE_W   = 3,
   parameter int CODE_MAX = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                psel,
   input  logic                penable,
   input  logic                pwrite,
   input  logic [ADDR_W-1:0]   paddr,
   input  logic [DATA_W-1:0]   pwdata,
   input  logic [DATA_W/8-1:0] pstrb,
   output logic [DATA_W-1:0]   prdata,
   output logic                pready,
   output logic                pslverr,
   input  logic [DATA_W-1:0]   strap_in,
   input  logic [DATA_W-1:0]   modoff_in,
   input  logic [CODE_W-1:0]   memsize_code,
   input  logic [DATA_W-1:0]   hw_set_rst,
   input  logic [DATA_W-1:0]   hw_set_aux,
   output logic                config_error
);

   import gcr_pkg::*;

   localparam int STRB_W = DATA_W / 8;
   localparam int WORDS  = LAST_OFS / 4 + 1;
   localparam int WIDX   = $clog2(WORDS);

   // elaboration-time parameter checks
   if (DATA_W != 32) begin : g_bad_width
      $error("gcr_regfile: DATA_W must be 32");
   end
   if ((LAST_OFS % 4) != 0) begin : g_bad_align
      $error("gcr_regfile: LAST_OFS must be word aligned");
   end
   if (LAST_OFS >= (1 << ADDR_W)) begin : g_bad_window
      $error("gcr_regfile: LAST_OFS outside address window");
   end
   if (WORDS <= IDX_HIGHEST) begin : g_bad_depth
      $error("gcr_regfile: map too small for the fixed words");
   end
   if (CODE_MAX >= (1 << CODE_W)) begin : g_bad_code
      $error("gcr_regfile: CODE_MAX does not fit CODE_W");
   end
   if (WIDX + 2 > ADDR_W) begin : g_bad_idx
      $error("gcr_regfile: index wider than address");
   end

   logic              err;
   logic              wr_ok;
   logic              rd_ok;
   logic [WIDX-1:0]   ridx;
   logic [DATA_W-1:0] memcfg_rst;
   logic [DATA_W-1:0] regs [WORDS];

   gcr_access_decode #(
      .ADDR_W   (ADDR_W),
      .STRB_W   (STRB_W),
      .LAST_OFS (LAST_OFS),
      .WIDX     (WIDX)
   ) u_dec (
      .psel    (psel),
      .penable (penable),
      .pwrite  (pwrite),
      .paddr   (paddr),
      .pstrb   (pstrb),
      .err     (err),
      .wr_ok   (wr_ok),
      .rd_ok   (rd_ok),
      .ridx    (ridx)
   );

   gcr_size_code #(
      .CODE_W    (CODE_W),
      .CODE_MAX  (CODE_MAX),
      .DATA_W    (DATA_W),
      .FIELD_LSB (8),
      .BASE      (32'h0000_1002)
   ) u_size (
      .code       (memsize_code),
      .cfg_err    (config_error),
      .memcfg_rst (memcfg_rst)
   );

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      logic [DATA_W-1:0] rv;
      logic [DATA_W-1:0] hs;
      logic              we;

      if (g == IDX_STRAP) begin : g_rv_strap
         assign rv = strap_in;
      end else if (g == IDX_MODOFF) begin : g_rv_modoff
         assign rv = modoff_in;
      end else if (g == IDX_MEMCFG) begin : g_rv_memcfg
         assign rv = memcfg_rst;
      end else begin : g_rv_fixed
         assign rv = DATA_W'(fixed_rst(g));
      end

      if (g == IDX_RSTSTAT) begin : g_hs_rst
         assign hs = hw_set_rst;
      end else if (g == IDX_CPSTAT) begin : g_hs_aux
         assign hs = hw_set_aux;
      end else begin : g_hs_none
         assign hs = '0;
      end

      assign we = wr_ok & (ridx == WIDX'(g));

      gcr_word #(
         .DATA_W (DATA_W),
         .POL    (pol_of(g))
      ) u_word (
         .clk     (clk),
         .rst_n   (rst_n),
         .rst_val (rv),
         .wr      (we),
         .wdata   (pwdata),
         .hw_set  (hs),
         .q       (regs[g])
      );
   end

   assign prdata  = rd_ok ? regs[ridx] : '0;
   assign pready  = 1'b1;
   assign pslverr = err;

endmodule

// File: rtl/gcr_regfile_chk.sv
module gcr_regfile_chk #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 12,
   parameter int CODE_W   = 3,
   parameter int CODE_MAX = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [DATA_W-1:0] prdata,
   input logic              pslverr,
   input logic              config_error,
   input logic [CODE_W-1:0] memsize_code,
   input logic [DATA_W-1:0] strap_in,
   input logic [DATA_W-1:0] hw_set_rst,
   input logic [DATA_W-1:0] w_strap,
   input logic [DATA_W-1:0] w_intstat,
   input logic [DATA_W-1:0] w_rststat,
   input logic [DATA_W-1:0] w_lock,
   input logic [DATA_W-1:0] w_modoff
);

   assert_ro_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ($stable(w_strap) && $stable(w_intstat)));

   assert_w1s_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((($past(w_lock) & ~w_lock) == '0) &&
                        (($past(w_modoff) & ~w_modoff) == '0)));

   assert_strap_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (w_strap == $past(strap_in)));

   assert_cfg_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      config_error == (memsize_code > CODE_W'(CODE_MAX)));

   assert_misalign_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && (paddr[1:0] != 2'b00)) |-> pslverr);

   assert_err_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && !pwrite && pslverr) |-> (prdata == '0));

   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((w_rststat & $past(hw_set_rst)) == $past(hw_set_rst)));

endmodule

bind gcr_regfile gcr_regfile_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .CODE_W   (CODE_W),
   .CODE_MAX (CODE_MAX)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .psel         (psel),
   .penable      (penable),
   .pwrite       (pwrite),
   .paddr        (paddr),
   .prdata       (prdata),
   .pslverr      (pslverr),
   .config_error (config_error),
   .memsize_code (memsize_code),
   .strap_in     (strap_in),
   .hw_set_rst   (hw_set_rst),
   .w_strap      (regs[gcr_pkg::IDX_STRAP]),
   .w_intstat    (regs[gcr_pkg::IDX_INTSTAT]),
   .w_rststat    (regs[gcr_pkg::IDX_RSTSTAT]),
   .w_lock       (regs[gcr_pkg::IDX_LOCK]),
   .w_modoff     (regs[gcr_pkg::IDX_MODOFF])
);

// File: tb/gcr_regfile_tb.sv
`timescale 1ns/1ps
module gcr_regfile_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0;
   logic        penable = 1'b0;
   logic        pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [3:0]  pstrb = '0;
   logic [31:0] prdata;
   logic        pready;
   logic        pslverr;
   logic [31:0] strap_in = 32'hA5A5_0F0F;
   logic [31:0] modoff_in = 32'h0000_0011;
   logic [2:0]  memsize_code = 3'd3;
   logic [31:0] hw_set_rst = '0;
   logic [31:0] hw_set_aux = '0;
   logic        config_error;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   logic [31:0] model [82];
   logic [31:0] set_a = '0;
   logic [31:0] set_b = '0;

   always #4 clk = ~clk;

   gcr_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
      .prdata(prdata), .pready(pready), .pslverr(pslverr),
      .strap_in(strap_in), .modoff_in(modoff_in),
      .memsize_code(memsize_code), .hw_set_rst(hw_set_rst),
      .hw_set_aux(hw_set_aux), .config_error(config_error)
   );

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // reference rules written from the requirements, keyed by byte offset
   function automatic int kind_of(int ofs); // 0 rw, 1 ro, 2 w1c, 3 w1s
      if (ofs == 'h000 || ofs == 'h004 || ofs == 'h040) return 1;
      if (ofs == 'h06C || ofs == 'h0D4) return 2;
      if (ofs == 'h070 || ofs == 'h07C) return 3;
      return 0;
   endfunction

   function automatic logic [31:0] reset_of(int ofs);
      int code;
      code = (memsize_code > 3'd4) ? 0 : int'(memsize_code);
      case (ofs)
         'h000: return 32'h04A92750;
         'h004: return strap_in;
         'h014: return 32'h0000FFFF;
         'h038: return 32'h00000003;
         'h03C: return 32'h0000035E;
         'h050: return 32'h0000004E;
         'h060: return 32'h1 << 19;
         'h06C: return 32'h80000000;
         'h078: return 32'h000000C0;
         'h07C: return modoff_in;
         'h098: return 32'h5A00F3CF;
         'h09C: return 32'h00001002 | (code << 8);
         'h13C: return 32'h00000008;
         'h140: return 32'h034730E4;
         'h144: return 32'h034730E4;
         default: return 32'h0;
      endcase
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 82; i++) model[i] = reset_of(i * 4);
   endtask

   task automatic xfer(input bit wr, input logic [11:0] a, input logic [31:0] d,
                       input logic [3:0] s, input string req);
      bit exp_err;
      logic [31:0] exp_rd;
      int idx;
      exp_err = (a[1:0] != 2'b00) || (a > 12'h144) || (wr && s != 4'hF);
      idx = int'(a) / 4;
      exp_rd = (wr || exp_err) ? 32'h0 : model[idx];
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
      @(negedge clk);
      penable = 1'b1; hw_set_rst = set_a; hw_set_aux = set_b;
      #1;
      check(pslverr == exp_err, {req, " err"}, 32'(pslverr), 32'(exp_err));
      if (!wr) check(prdata == exp_rd, {req, " rdata"}, prdata, exp_rd);
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; hw_set_rst = '0; hw_set_aux = '0;
      if (wr && !exp_err) begin
         case (kind_of(idx * 4))
            1: ;
            2: model[idx] = model[idx] & ~d;
            3: model[idx] = model[idx] | d;
            default: model[idx] = d;
         endcase
      end
      model[27] = model[27] | set_a;
      model[53] = model[53] | set_b;
   endtask

   task automatic rd(input logic [11:0] a, input string req);
      xfer(1'b0, a, 32'h0, 4'h0, req);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input string req);
      xfer(1'b1, a, d, 4'hF, req);
   endtask

   // per-cycle comparison of the flag outputs against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(config_error == (memsize_code > 3'd4), "R8 config_error",
               32'(config_error), 32'(memsize_code > 3'd4));
         check(pready == 1'b1, "R9 pready", 32'(pready), 32'h1);
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R2 R6 R7: reset image with code 3
      do_reset();
      for (int i = 0; i < 82; i++) rd(12'(i * 4), "R2/R6/R7 reset image");
      rd(12'h09C, "R7 memcfg code3");

      // R1 R3 R4 R5: write a pattern everywhere, read it all back
      for (int i = 0; i < 82; i++)
         wr(12'(i * 4), (32'h3C3CA5A5 ^ (32'(i) * 32'h00010203)), "R1 fill");
      for (int i = 0; i < 82; i++) rd(12'(i * 4), "R1/R3/R4/R5 readback");

      // R3 read-only words keep value
      wr(12'h000, 32'hFFFFFFFF, "R3 wr id"); rd(12'h000, "R3 id");
      wr(12'h004, 32'h0, "R3 wr strap"); rd(12'h004, "R3 strap");
      wr(12'h040, 32'h12345678, "R3 wr intstat"); rd(12'h040, "R3 intstat");

      // R5 sticky bits
      wr(12'h070, 32'h00000001, "R5 set"); wr(12'h070, 32'h0, "R5 zero");
      rd(12'h070, "R5 lock sticky");
      wr(12'h07C, 32'hF0000000, "R5 set modoff"); rd(12'h07C, "R5 modoff");

      // R4 clear-on-one
      wr(12'h0D4, 32'hFFFFFFFF, "R4 clr all"); rd(12'h0D4, "R4 aux cleared");

      // R10 hardware strobes, and set beating a clearing write
      set_b = 32'h0000_0A0A; rd(12'h0D0, "R10 idle read"); set_b = '0;
      rd(12'h0D4, "R10 aux set");
      set_a = 32'h0000_00F0;
      wr(12'h06C, 32'hFFFFFFFF, "R10 set wins");
      set_a = '0;
      rd(12'h06C, "R10 rststat after collision");
      wr(12'h06C, 32'h0000_0030, "R4 partial clear"); rd(12'h06C, "R4 rststat");

      // R9 illegal accesses
      rd(12'h148, "R9 read past end");
      wr(12'h148, 32'hDEADBEEF, "R9 write past end");
      rd(12'h144, "R9 last word ok");
      rd(12'hFFC, "R9 window top");
      rd(12'h002, "R9 misaligned read");
      wr(12'h009, 32'hDEADBEEF, "R9 misaligned write");
      xfer(1'b1, 12'h008, 32'hCAFEF00D, 4'b0011, "R9 partial strobe");
      rd(12'h008, "R9 word untouched");

      // R7 boundary code 4 and R6 with new pins
      strap_in = 32'h1357_9BDF; modoff_in = 32'h8000_0001; memsize_code = 3'd4;
      do_reset();
      rd(12'h09C, "R7 code4"); rd(12'h004, "R6 strap"); rd(12'h07C, "R6 modoff");

      // R8 illegal codes fall back to zero
      memsize_code = 3'd7;
      do_reset();
      rd(12'h09C, "R8 code7 treated as 0");
      memsize_code = 3'd5;
      do_reset();
      rd(12'h09C, "R8 code5 treated as 0");
      memsize_code = 3'd0;
      do_reset();
      rd(12'h09C, "R7 code0");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule